// File: doc/BRIEF.md
# Derivative Interrupt Acceptance Gate

This block decides whether a peripheral-emulation interrupt is taken by the processor core. Two request sources feed it: an active-low request pin driven by external hardware that stands in for on-chip peripherals, and the core's internal serial-port interrupt. The two are merged into one request. The merged request is looked at in a single time slot of each machine cycle. If that look finds the request present, software has enabled this interrupt, and no interrupt routine is running, the block issues a one-cycle accept pulse and presents the fixed vector address.

Nothing is remembered between looks. A request that has gone away by the sampling slot, or that is present only while the block is masked or busy, is lost. The requesting source must therefore hold its request until it sees the vector. The block keeps its own enable flag, which enable and disable instruction strobes set and clear. It also keeps an in-service flag. An accept sets this flag and a return-from-interrupt strobe clears it.

Top module: `drvirq_accept`

## Requirements
- R1: After reset `take` is 0, `vec_addr` is 0, `irq_en` is 0 and `in_service` is 0.
- R2: `ext_req_n` is active low. A 0 on it is a request, and a 1 on it (the pulled-up idle level) is no request.
- R3: A request on `ser_req` (active high) alone is taken exactly as an external one is. The two sources are ORed.
- R4: The merged request is sampled only on a clock edge where `slot` equals SAMPLE_SLOT (default 6). A request that is present in other slots and gone by that slot gives no accept.
- R5: `en_set` sets `irq_en` and `en_clr` clears it, one cycle after the strobe. When both are high, clear wins. While `irq_en` is 0, requests are ignored and not stored, so enabling later with the request gone yields no accept.
- R6: While `in_service` is 1, no accept occurs. A `reti` strobe clears `in_service` one cycle later, and after that a request that is still held is taken at the next sampling slot.
- R7: An accept appears as `take` high for exactly one cycle. It starts on the edge after the sampling edge, and `in_service` is 1 from that same cycle on.
- R8: `vec_addr` equals VECTOR (default 12'h005) while `take` is 1 and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req_n | input | 1 | External peripheral-emulation request, active low |
| ser_req | input | 1 | Internal serial interrupt request, active high |
| slot | input | SLOT_W | Current time slot number within the machine cycle |
| en_set | input | 1 | Enable-interrupt instruction strobe |
| en_clr | input | 1 | Disable-interrupt instruction strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-cycle accept pulse |
| vec_addr | output | VEC_W | Vector address, valid during `take` |
| irq_en | output | 1 | Current enable flag |
| in_service | output | 1 | Interrupt routine running |

## Verification
The checker assumes that `slot` is a clean counter value each cycle. It also assumes that `reti` arrives only to end a routine that is running, so it never lands in the same cycle as a sampling edge that could accept. The bench generates `slot` as a free-running count from 0 to 9. It issues `reti` only after an accept has been seen and well away from slot 6. Requests are raised and dropped at chosen slot positions: before the sampling slot, across it while masked, and across it while busy.

// File: rtl/drvirq_pkg.sv
package drvirq_pkg;
   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } pol_e;
endpackage

// File: rtl/drvirq_merge.sv
module drvirq_merge
   import drvirq_pkg::*;
#(
   parameter pol_e EXT_POL = POL_LOW
) (
   input  logic ext_pin,
   input  logic ser_req,
   output logic req_any
);
   logic ext_active;

   generate
      if (EXT_POL == POL_LOW) begin : g_low
         assign ext_active = ~ext_pin;
      end else begin : g_high
         assign ext_active = ext_pin;
      end
   endgenerate

   assign req_any = ext_active | ser_req;
endmodule

// File: rtl/drvirq_enable.sv
module drvirq_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic en_set,
   input  logic en_clr,
   output logic en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (en_clr) en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
   end
endmodule

// File: rtl/drvirq_gate.sv
module drvirq_gate #(
   parameter int          SLOT_W      = 4,
   parameter int          SAMPLE_SLOT = 6,
   parameter int          VEC_W       = 12,
   parameter logic [11:0] VECTOR      = 12'h005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_any,
   input  logic [SLOT_W-1:0] slot,
   input  logic              en_q,
   input  logic              reti,
   output logic              take,
   output logic [VEC_W-1:0]  vec_addr,
   output logic              busy
);
   localparam logic [SLOT_W-1:0] SLOT_HIT = SLOT_W'(SAMPLE_SLOT);
   localparam logic [VEC_W-1:0]  VEC_VAL  = VEC_W'(VECTOR);

   logic in_slot;
   logic accept;

   assign in_slot = (slot == SLOT_HIT);
   assign accept  = in_slot & req_any & en_q & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take     <= 1'b0;
         vec_addr <= '0;
         busy     <= 1'b0;
      end else begin
         take     <= accept;
         vec_addr <= accept ? VEC_VAL : '0;
         if (accept)    busy <= 1'b1;
         else if (reti) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/drvirq_accept.sv
module drvirq_accept
   import drvirq_pkg::*;
#(
   parameter int          SLOT_W      = 4,
   parameter int          SAMPLE_SLOT = 6,
   parameter int          VEC_W       = 12,
   parameter logic [11:0] VECTOR      = 12'h005,
   parameter pol_e        EXT_POL     = POL_LOW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_req_n,
   input  logic              ser_req,
   input  logic [SLOT_W-1:0] slot,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              reti,
   output logic              take,
   output logic [VEC_W-1:0]  vec_addr,
   output logic              irq_en,
   output logic              in_service
);
   initial begin
      if (SLOT_W < 1 || SLOT_W > 8)
         $error("drvirq_accept: SLOT_W out of range");
      if (SAMPLE_SLOT < 0 || SAMPLE_SLOT >= (1 << SLOT_W))
         $error("drvirq_accept: SAMPLE_SLOT not reachable");
      if (VEC_W < 1 || VEC_W > 12)
         $error("drvirq_accept: VEC_W out of range");
   end

   logic req_any;

   drvirq_merge #(.EXT_POL(EXT_POL)) u_merge (
      .ext_pin (ext_req_n),
      .ser_req (ser_req),
      .req_any (req_any)
   );

   drvirq_enable u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_set (en_set),
      .en_clr (en_clr),
      .en_q   (irq_en)
   );

   drvirq_gate #(
      .SLOT_W      (SLOT_W),
      .SAMPLE_SLOT (SAMPLE_SLOT),
      .VEC_W       (VEC_W),
      .VECTOR      (VECTOR)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_any  (req_any),
      .slot     (slot),
      .en_q     (irq_en),
      .reti     (reti),
      .take     (take),
      .vec_addr (vec_addr),
      .busy     (in_service)
   );
endmodule

// File: rtl/drvirq_accept_chk.sv
module drvirq_accept_chk #(
   parameter int          SLOT_W      = 4,
   parameter int          SAMPLE_SLOT = 6,
   parameter int          VEC_W       = 12,
   parameter logic [11:0] VECTOR      = 12'h005
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_req_n,
   input logic              ser_req,
   input logic [SLOT_W-1:0] slot,
   input logic              en_set,
   input logic              en_clr,
   input logic              reti,
   input logic              take,
   input logic [VEC_W-1:0]  vec_addr,
   input logic              irq_en,
   input logic              in_service
);
   // R4
   take_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(slot == SLOT_W'(SAMPLE_SLOT)));

   // R2
   take_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(!ext_req_n || ser_req));

   // R5
   take_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(irq_en));

   // R6
   no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(!in_service));

   // R6
   reti_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && in_service) |=> !in_service);

   // R7
   take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   // R7
   take_marks_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> in_service);

   // R8
   vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (vec_addr == VEC_W'(VECTOR)));

   // R8
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> (vec_addr == '0));

   // R5
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !irq_en);
endmodule

bind drvirq_accept drvirq_accept_chk #(
   .SLOT_W      (SLOT_W),
   .SAMPLE_SLOT (SAMPLE_SLOT),
   .VEC_W       (VEC_W),
   .VECTOR      (VECTOR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_req_n  (ext_req_n),
   .ser_req    (ser_req),
   .slot       (slot),
   .en_set     (en_set),
   .en_clr     (en_clr),
   .reti       (reti),
   .take       (take),
   .vec_addr   (vec_addr),
   .irq_en     (irq_en),
   .in_service (in_service)
);

// File: tb/drvirq_accept_tb.sv
module drvirq_accept_tb;
   localparam int SLOT_W = 4;
   localparam int VEC_W  = 12;
   localparam logic [VEC_W-1:0] EXP_VEC = 12'h005;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ext_req_n = 1'b1;
   logic              ser_req = 1'b0;
   logic [SLOT_W-1:0] slot = '0;
   logic              en_set = 1'b0;
   logic              en_clr = 1'b0;
   logic              reti = 1'b0;
   logic              take;
   logic [VEC_W-1:0]  vec_addr;
   logic              irq_en;
   logic              in_service;

   int total = 0;
   int bad   = 0;

   drvirq_accept u_dut (
      .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .ser_req(ser_req),
      .slot(slot), .en_set(en_set), .en_clr(en_clr), .reti(reti),
      .take(take), .vec_addr(vec_addr), .irq_en(irq_en), .in_service(in_service)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) slot <= (slot == 4'd9) ? 4'd0 : slot + 4'd1;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts accepts over n cycles, widest pulse, last vector, slot of last sample
   task automatic observe(input int n, output int takes, output int widest,
                          output int vec, output int hit_slot);
      int run = 0;
      takes = 0; widest = 0; vec = 0; hit_slot = -1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (take) begin
            if (run == 0) takes++;
            run++;
            vec = int'(vec_addr);
            hit_slot = int'(slot);
            if (run > widest) widest = run;
         end else begin
            run = 0;
            if (vec_addr != '0) vec = -1;
         end
      end
   endtask

   task automatic wait_slot(input int k);
      do begin
         @(negedge clk); #1;
      end while (int'(slot) != k);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); #1; s = 1'b1;
      @(negedge clk); #1; s = 1'b0;
   endtask

   task automatic end_routine;
      wait_slot(1);
      reti = 1'b1;
      @(negedge clk); #1; reti = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 take", take, 0);
      check("R1 vec_addr", int'(vec_addr), 0);
      check("R1 irq_en", irq_en, 0);
      check("R1 in_service", in_service, 0);
   endtask

   task automatic t_enable;
      pulse(en_set);
      check("R5 set", irq_en, 1);
      @(negedge clk); #1; en_set = 1'b1; en_clr = 1'b1;
      @(negedge clk); #1; en_set = 1'b0; en_clr = 1'b0;
      check("R5 clear wins", irq_en, 0);
      pulse(en_set);
      check("R5 set again", irq_en, 1);
   endtask

   task automatic t_idle_pin;
      int tk, wd, vc, hs;
      observe(12, tk, wd, vc, hs);
      check("R2 high pin no take", tk, 0);
      check("R8 vec idle", vc, 0);
   endtask

   task automatic t_ext_accept;
      int tk, wd, vc, hs;
      wait_slot(2);
      ext_req_n = 1'b0;
      observe(10, tk, wd, vc, hs);
      ext_req_n = 1'b1;
      check("R2 ext low taken", tk, 1);
      check("R7 pulse width", wd, 1);
      check("R7 sampled in slot 6", hs, 6);
      check("R8 vector", vc, int'(EXP_VEC));
      check("R7 in_service set", in_service, 1);
      end_routine();
      check("R6 reti clears", in_service, 0);
   endtask

   task automatic t_ser_accept;
      int tk, wd, vc, hs;
      wait_slot(3);
      ser_req = 1'b1;
      observe(10, tk, wd, vc, hs);
      ser_req = 1'b0;
      check("R3 serial taken", tk, 1);
      check("R3 vector", vc, int'(EXP_VEC));
      end_routine();
   endtask

   task automatic t_drop_before;
      int tk, wd, vc, hs;
      wait_slot(2);
      ext_req_n = 1'b0;
      for (int i = 0; i < 3; i++) begin @(negedge clk); #1; end
      ext_req_n = 1'b1;
      observe(15, tk, wd, vc, hs);
      check("R4 dropped before slot", tk, 0);
      check("R4 in_service", in_service, 0);
   endtask

   task automatic t_masked;
      int tk, wd, vc, hs;
      pulse(en_clr);
      ext_req_n = 1'b0;
      observe(15, tk, wd, vc, hs);
      ext_req_n = 1'b1;
      check("R5 masked no take", tk, 0);
      pulse(en_set);
      observe(15, tk, wd, vc, hs);
      check("R5 not latched", tk, 0);
      check("R5 in_service after mask", in_service, 0);
   endtask

   task automatic t_busy;
      int tk, wd, vc, hs;
      wait_slot(2);
      ser_req = 1'b1;
      observe(10, tk, wd, vc, hs);
      check("R6 first take", tk, 1);
      observe(25, tk, wd, vc, hs);
      check("R6 busy no take", tk, 0);
      end_routine();
      observe(10, tk, wd, vc, hs);
      ser_req = 1'b0;
      check("R6 retaken after reti", tk, 1);
      end_routine();
   endtask

   initial begin
      #5000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_enable();
      t_idle_pin();
      t_ext_accept();
      t_ser_accept();
      t_drop_before();
      t_masked();
      t_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule